// File: doc/BRIEF.md
# Programmable Sum-of-Products Output Cells

This block models the output side of a small programmable logic array. Dedicated inputs and one feedback line per output are each offered to the array in true and complement form. Every product term is an AND over the literals that its mask connects. Each output cell ORs a fixed group of `PTS` terms into a sum. A two-bit mode field then picks whether the pin shows that sum directly or through a flip-flop, and whether the pin is active-high or active-low.

Three more kinds of term act alongside the sums. One output-enable term per cell drives that cell's pad enable. One shared term clears every cell register at once, without waiting for the clock. A second shared term sets every register at the next rising clock edge. The configuration (term masks and mode bits) is written one row at a time through a parallel write port. A synchronous active-low reset returns the configuration to its erased state and clears every register.

The board side of each pin is modelled by `pad_in`, which is the level seen at the pin. In combinational mode the array's feedback for a cell reads that level. In registered mode it reads the cell register.

Top module: `pldm_sop_array`

## Requirements
- R1: Array signal j (inputs `dat_in[0..N_IN-1]` first, then feedback of cell 0, 1, ...) gives literal bit 2j (true) and literal bit 2j+1 (complement). A term is 1 when every literal whose mask bit is 1 is 1. A mask that connects both literals of one signal therefore always yields 0, and an all-zero mask yields 1.
- R2: The sum of cell k is the OR of the terms in rows k*PTS to k*PTS+PTS-1.
- R3: The mode of cell k is held in bits {2k+1, 2k} of the mode row as {S1,S0}. 00 = registered active-low, 01 = registered active-high, 10 = combinational active-low, 11 = combinational active-high. With S1=1, `pad_out[k]` is the sum, inverted when S0=0, in the same cycle.
- R4: With S1=0, the cell register loads the sum on each rising edge, and `pad_out[k]` shows the register, inverted when S0=0.
- R5: Feedback of cell k is its register when S1=0 and `pad_in[k]` when S1=1.
- R6: While the shared clear term (row N_OUT*PTS+N_OUT) is 1, every cell register is 0 at once. The clear term wins over the set term.
- R7: When the shared set term (row N_OUT*PTS+N_OUT+1) is 1 and the clear term is 0, every cell register becomes 1 at the next rising edge.
- R8: While `rst_n` is low at a rising edge, every register is cleared, every term row becomes all ones and every mode bit becomes 1. A cell switched afterwards to registered active-low with erased terms then shows 1.
- R9: `pad_oe[k]` equals the enable term in row N_OUT*PTS+k.
- R10: With `cfg_we` high, `rst_n` high and `cfg_addr` below N_OUT*PTS+N_OUT+2, that row takes `cfg_wdata` at the rising edge. Address N_OUT*PTS+N_OUT+2 takes `cfg_wdata[2*N_OUT-1:0]` as the mode row. Higher addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration row write strobe |
| cfg_addr | input | AW | Configuration row address |
| cfg_wdata | input | 2*(N_IN+N_OUT) | Row mask or mode bits |
| dat_in | input | N_IN | Dedicated array inputs |
| pad_in | input | N_OUT | Level seen at each output pin |
| pad_out | output | N_OUT | Value driven to each pin |
| pad_oe | output | N_OUT | Drive enable for each pin |

## Verification
A register that is wrong shows on `pad_out` of a registered cell at the very next negative-edge sample. It also spreads through feedback into the other cells' sums within one more edge. A stored mask or mode bit that is wrong shows in the same cycle on a combinational pin or on `pad_oe`. A clear or set that fires late or early shows as one wrong registered sample. The bench's reference model is updated on every clock edge and compared on every clock, so any of these faults is caught within one or two cycles of the stimulus that exposes it.

// File: rtl/pldm_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the sum-of-products output cells.
// Assumes: mode field is {S1,S0}; S1 selects combinational, S0 active-high.
package pldm_pkg;

    typedef enum logic [1:0] {
        MODE_REG_LOW  = 2'b00,
        MODE_REG_HIGH = 2'b01,
        MODE_CMB_LOW  = 2'b10,
        MODE_CMB_HIGH = 2'b11
    } cell_mode_e;

    // True when the mode selects the flip-flop path.
    function automatic logic mode_is_reg(input logic [1:0] m);
        return (cell_mode_e'(m) == MODE_REG_LOW) || (cell_mode_e'(m) == MODE_REG_HIGH);
    endfunction

    // True when the mode selects active-high output.
    function automatic logic mode_is_high(input logic [1:0] m);
        return (cell_mode_e'(m) == MODE_REG_HIGH) || (cell_mode_e'(m) == MODE_CMB_HIGH);
    endfunction

endpackage

// File: rtl/pldm_cfg_store.sv
`timescale 1ns/1ps
// Configuration storage: N_ROWS mask rows plus one mode row at address N_ROWS.
// Assumes: synchronous active-low reset returns every bit to 1 (erased).
module pldm_cfg_store #(
    parameter int ROW_W  = 12,
    parameter int N_ROWS = 20,
    parameter int MODE_W = 4,
    parameter int AW     = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [AW-1:0]           addr,
    input  logic [ROW_W-1:0]        wdata,
    output logic [N_ROWS*ROW_W-1:0] rows,
    output logic [MODE_W-1:0]       mode
);

    localparam int MODE_ADDR = N_ROWS;

    for (genvar i = 0; i < N_ROWS; i++) begin : g_row
        // Hold one term mask; load it when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rows[i*ROW_W +: ROW_W] <= '1;
            end else if (we && (addr == AW'(i))) begin
                rows[i*ROW_W +: ROW_W] <= wdata;
            end
        end

        AST_ROW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (we && (addr == AW'(i))) |=> (rows[i*ROW_W +: ROW_W] == $past(wdata))); // R10
    end

    // Hold the per-cell mode bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= '1;
        end else if (we && (addr == AW'(MODE_ADDR))) begin
            mode <= wdata[MODE_W-1:0];
        end
    end

    AST_BAD_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (addr > AW'(MODE_ADDR))) |=> ($stable(rows) && $stable(mode))); // R10

endmodule

// File: rtl/pldm_pterm.sv
`timescale 1ns/1ps
// One product term: AND of every literal whose mask bit is set.
// Assumes: empty mask gives 1; true and complement of one signal give 0.
module pldm_pterm #(
    parameter int LIT_W = 12
) (
    input  logic [LIT_W-1:0] lits,
    input  logic [LIT_W-1:0] mask,
    output logic             hit
);

    // Unconnected literals are forced to 1 before the AND.
    always_comb begin
        hit = &(lits | ~mask);
    end

endmodule

// File: rtl/pldm_macrocell.sv
`timescale 1ns/1ps
// One output cell: OR of NPT terms, optional register, polarity, enable, feedback.
// Assumes: ar_hit clears asynchronously; sp_hit and rst_n act on the clock edge.
module pldm_macrocell
    import pldm_pkg::*;
#(
    parameter int NPT   = 8,
    parameter int LIT_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LIT_W-1:0]     lits,
    input  logic [NPT*LIT_W-1:0] masks,
    input  logic [LIT_W-1:0]     oe_mask,
    input  logic                 ar_hit,
    input  logic                 sp_hit,
    input  logic [1:0]           mode,
    input  logic                 pin_in,
    output logic                 pin_out,
    output logic                 pin_oe,
    output logic                 fb
);

    logic [NPT-1:0] hits;
    logic           sum;
    logic           q_r;
    logic           pre_pol;

    for (genvar t = 0; t < NPT; t++) begin : g_term
        pldm_pterm #(.LIT_W(LIT_W)) i_term (
            .lits (lits),
            .mask (masks[t*LIT_W +: LIT_W]),
            .hit  (hits[t])
        );
    end

    pldm_pterm #(.LIT_W(LIT_W)) i_oe_term (
        .lits (lits),
        .mask (oe_mask),
        .hit  (pin_oe)
    );

    // Fixed OR of this cell's terms.
    always_comb begin
        sum = |hits;
    end

    // Cell register: async clear, sync reset, sync set, else load the sum.
    always_ff @(posedge clk or posedge ar_hit) begin
        if (ar_hit) begin
            q_r <= 1'b0;
        end else if (!rst_n) begin
            q_r <= 1'b0;
        end else if (sp_hit) begin
            q_r <= 1'b1;
        end else begin
            q_r <= sum;
        end
    end

    // Output path selection and polarity.
    always_comb begin
        pre_pol = mode_is_reg(mode) ? q_r : sum;
        pin_out = mode_is_high(mode) ? pre_pol : ~pre_pol;
    end

    // Feedback source follows the mode.
    always_comb begin
        fb = mode_is_reg(mode) ? q_r : pin_in;
    end

    AST_CLEAR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ar_hit |-> !q_r); // R6
    AST_SET_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_hit && !ar_hit) |=> (q_r || ar_hit)); // R7
    AST_REG_TRACKS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (!ar_hit && !sp_hit) |=> ((q_r == $past(sum)) || ar_hit)); // R4
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !q_r); // R8

endmodule

// File: rtl/pldm_sop_array.sv
`timescale 1ns/1ps
// Top: literal generation, shared clear/set terms, config store and output cells.
// Assumes: PTS between 8 and 16; feedback comes only from registers or pad_in,
// so the array has no combinational loop inside the block.
module pldm_sop_array #(
    parameter int  N_IN     = 4,
    parameter int  N_OUT    = 2,
    parameter int  PTS      = 8,
    localparam int N_SIG    = N_IN + N_OUT,
    localparam int ROW_W    = 2 * N_SIG,
    localparam int ROW_OE   = N_OUT * PTS,
    localparam int ROW_AR   = ROW_OE + N_OUT,
    localparam int ROW_SP   = ROW_AR + 1,
    localparam int N_FULL   = ROW_SP + 1,
    localparam int N_ADDR   = N_FULL + 1,
    localparam int AW       = $clog2(N_ADDR + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [ROW_W-1:0] cfg_wdata,
    input  logic [N_IN-1:0]  dat_in,
    input  logic [N_OUT-1:0] pad_in,
    output logic [N_OUT-1:0] pad_out,
    output logic [N_OUT-1:0] pad_oe
);

    logic [N_FULL*ROW_W-1:0] rows;
    logic [2*N_OUT-1:0]      modes;
    logic [N_OUT-1:0]        fb;
    logic [N_SIG-1:0]        sig;
    logic [ROW_W-1:0]        lits;
    logic                    ar_hit;
    logic                    sp_hit;

    pldm_cfg_store #(
        .ROW_W  (ROW_W),
        .N_ROWS (N_FULL),
        .MODE_W (2 * N_OUT),
        .AW     (AW)
    ) i_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rows  (rows),
        .mode  (modes)
    );

    // Array signals: inputs in the low positions, feedback above.
    always_comb begin
        sig = {fb, dat_in};
    end

    for (genvar j = 0; j < N_SIG; j++) begin : g_lit
        // True literal at even bit, complement at odd bit.
        always_comb begin
            lits[2*j]   = sig[j];
            lits[2*j+1] = ~sig[j];
        end
    end

    pldm_pterm #(.LIT_W(ROW_W)) i_ar_term (
        .lits (lits),
        .mask (rows[ROW_AR*ROW_W +: ROW_W]),
        .hit  (ar_hit)
    );

    pldm_pterm #(.LIT_W(ROW_W)) i_sp_term (
        .lits (lits),
        .mask (rows[ROW_SP*ROW_W +: ROW_W]),
        .hit  (sp_hit)
    );

    for (genvar k = 0; k < N_OUT; k++) begin : g_cell
        pldm_macrocell #(.NPT(PTS), .LIT_W(ROW_W)) i_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .lits    (lits),
            .masks   (rows[k*PTS*ROW_W +: PTS*ROW_W]),
            .oe_mask (rows[(ROW_OE+k)*ROW_W +: ROW_W]),
            .ar_hit  (ar_hit),
            .sp_hit  (sp_hit),
            .mode    (modes[2*k +: 2]),
            .pin_in  (pad_in[k]),
            .pin_out (pad_out[k]),
            .pin_oe  (pad_oe[k]),
            .fb      (fb[k])
        );
    end

endmodule

// File: tb/test_pldm_sop_array.sv
`timescale 1ns/1ps
// Self-checking bench with a behavioural reference model compared every clock.
module test_pldm_sop_array;

    localparam int NI     = 4;
    localparam int NO     = 2;
    localparam int PT     = 8;
    localparam int NS     = NI + NO;
    localparam int RW     = 2 * NS;
    localparam int R_OE   = NO * PT;
    localparam int R_AR   = R_OE + NO;
    localparam int R_SP   = R_AR + 1;
    localparam int R_MODE = R_SP + 1;
    localparam int AW     = $clog2(R_MODE + 2);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [RW-1:0] cfg_wdata = '0;
    logic [NI-1:0] dat_in = '0;
    logic [NO-1:0] pad_in = '0;
    logic [NO-1:0] pad_out;
    logic [NO-1:0] pad_oe;

    int    n_checks = 0;
    int    n_fails  = 0;
    string tag = "R8";

    logic [RW-1:0]   shadow [R_MODE];
    logic [2*NO-1:0] smode = '1;
    logic [NO-1:0]   mq = '0;

    pldm_sop_array #(.N_IN(NI), .N_OUT(NO), .PTS(PT)) i_pldm_sop_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .dat_in    (dat_in),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    always #10 clk = ~clk;

    // Reference: term is true unless a connected literal is false.
    function automatic logic ref_term(input logic [RW-1:0] m, input logic [RW-1:0] l);
        for (int b = 0; b < RW; b++) if (m[b] && !l[b]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [RW-1:0] ref_lits();
        logic [RW-1:0] l;
        for (int j = 0; j < NS; j++) begin
            logic v;
            if (j < NI) v = dat_in[j];
            else v = smode[2*(j-NI)+1] ? pad_in[j-NI] : mq[j-NI];
            l[2*j] = v;
            l[2*j+1] = !v;
        end
        return l;
    endfunction

    function automatic logic ref_sum(input int k, input logic [RW-1:0] l);
        logic s = 1'b0;
        for (int t = 0; t < PT; t++) s = s | ref_term(shadow[k*PT+t], l);
        return s;
    endfunction

    // Model update at each rising edge, from values held since the last negedge.
    always @(posedge clk) begin
        logic [NO-1:0] nq;
        logic [RW-1:0] l;
        if (!rst_n) begin
            mq = '0;
            for (int r = 0; r < R_MODE; r++) shadow[r] = '1;
            smode = '1;
        end else begin
            l = ref_lits();
            for (int k = 0; k < NO; k++) begin
                if (ref_term(shadow[R_AR], l)) nq[k] = 1'b0;
                else if (ref_term(shadow[R_SP], l)) nq[k] = 1'b1;
                else nq[k] = ref_sum(k, l);
            end
            if (cfg_we) begin
                if (int'(cfg_addr) < R_MODE) shadow[cfg_addr] = cfg_wdata;
                else if (int'(cfg_addr) == R_MODE) smode = cfg_wdata[2*NO-1:0];
            end
            mq = nq;
        end
    end

    // Compare both outputs of every cell against the model.
    task automatic compare();
        logic [RW-1:0] l;
        l = ref_lits();
        for (int k = 0; k < NO; k++) begin
            logic v;
            logic e;
            logic eo;
            v  = smode[2*k+1] ? ref_sum(k, l) : mq[k];
            e  = smode[2*k] ? v : !v;
            eo = ref_term(shadow[R_OE+k], l);
            n_checks++;
            if (pad_out[k] !== e) begin
                n_fails++;
                $display("FAIL %s pad_out[%0d] actual %b expected %b", tag, k, pad_out[k], e);
            end
            n_checks++;
            if (pad_oe[k] !== eo) begin
                n_fails++;
                $display("FAIL R9 (%s) pad_oe[%0d] actual %b expected %b", tag, k, pad_oe[k], eo);
            end
        end
    endtask

    task automatic step();
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input int a, input logic [RW-1:0] d);
        step();
        cfg_we = 1'b1;
        cfg_addr = AW'(a);
        cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic run(input int n);
        for (int c = 0; c < n; c++) begin
            step();
            dat_in = NI'($urandom);
            pad_in = NO'($urandom);
        end
    endtask

    function automatic logic [RW-1:0] rmask(input int nsig);
        logic [RW-1:0] m = '0;
        for (int j = 0; j < nsig; j++) begin
            case ($urandom % 8)
                5: m[2*j] = 1'b1;
                6: m[2*j+1] = 1'b1;
                7: m[2*j +: 2] = 2'b11;
                default: ;
            endcase
        end
        return m;
    endfunction

    task automatic load_random(input logic [1:0] m0, input logic [1:0] m1);
        for (int r = 0; r < R_OE; r++) wr(r, rmask(NS));
        for (int k = 0; k < NO; k++) wr(R_OE + k, rmask(NS));
        wr(R_MODE, RW'({m1, m0}));
    endtask

    initial begin
        // R8: reset state, then registered active-low with erased terms shows 1.
        tag = "R8";
        repeat (3) step();
        rst_n = 1'b1;
        run(2);
        wr(R_MODE, '0);
        run(3);

        // R10: writes above the mode row change nothing.
        tag = "R10";
        wr(R_MODE + 1, '0);
        wr((1 << AW) - 1, '0);
        run(3);

        // R1: both literals of one input give 0; then dat_in[0] & ~dat_in[1].
        tag = "R1";
        wr(R_MODE, RW'(4'b1111));
        wr(0, RW'(12'b0000_0000_0011));
        run(4);
        wr(0, RW'(12'b0000_0000_1001));
        run(12);
        wr(1, RW'(12'b0000_0000_0000));
        run(3);
        wr(1, '1);

        // R6/R7: clear on in2&in3, set on in1, registered cells.
        tag = "R6/R7";
        wr(R_MODE, RW'(4'b0100));
        wr(R_AR, RW'(12'b0000_0101_0000));
        wr(R_SP, RW'(12'b0000_0000_0100));
        run(40);
        wr(R_AR, '1);
        wr(R_SP, '1);

        // Mode sweep with random masks: R2/R5 throughout, R3 combinational, R4 registered.
        for (int m = 0; m < 4; m++) begin
            tag = (m < 2) ? "R2/R4/R5" : "R2/R3/R5";
            load_random(2'(m), 2'(m));
            run(40);
        end
        tag = "R2/R3/R4/R5";
        load_random(2'b10, 2'b01);
        run(40);
        load_random(2'b00, 2'b11);
        run(40);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #3_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule